// File: doc/BRIEF.md
# Single-Step Non-Restoring Divide Unit

This block computes one step of a one-bit-per-step non-restoring division. Each step takes a partial remainder and a divisor. It shifts the remainder left by one, moving the current T bit into the low end. It then adds the divisor to the shifted value or subtracts it, as the stored status bits direct. The outputs are the new partial remainder, a new Q flag and a quotient bit placed in T. Control code calls the step over and over to build a quotient one bit at a time.

A small registered wrapper holds the three status bits Q, M and T. An initialise input loads M and Q and clears T. A separate T-write input lets the surrounding datapath move a dividend bit into T between steps, the way a rotate-through-T operation would.

The partial remainder is not stored. The caller feeds back the combinational remainder output as the next step's remainder input. This lets a test run 32 steps and compare the collected T bits with an unsigned quotient. Setup sequences for signed division and the final quotient correction lie outside this block.

Top module: `divstep_unit`

## Requirements
- R1: A synchronous active-high reset clears Q, M and T to 0. It takes effect even after the flags have been loaded with non-zero values.
- R2: When `init` is high, the next clock edge loads M from `init_m` and Q from `init_q` and clears T. No division step happens in that cycle, even if `step` is also high.
- R3: When `t_wr` is high and neither `init` nor `step` is high, the next clock edge loads T from `t_wdata`. Q and M are left unchanged.
- R4: `rem_out` is computed from the shifted value, which is `{rem_in[WIDTH-2:0], T}`. When Q equals M, `rem_out` is the shifted value minus `divisor`; otherwise it is the shifted value plus `divisor`. Both results are taken modulo 2^WIDTH and use the current registered Q, M and T.
- R5: A step (`step` high, `init` low) sets Q on the clock edge to `rem_in[WIDTH-1]` XOR c XOR M. Here c is the borrow-out of the subtraction or the carry-out of the addition.
- R6: After a step, T is 1 exactly when the new Q equals M, and 0 otherwise.
- R7: M changes only through `init`. Steps and T writes leave it as it was.
- R8: With `init`, `step` and `t_wr` all low, Q, M and T hold their values.
- R9: When `step` and `t_wr` are high in the same cycle, the step result decides T and `t_wdata` is ignored.
- R10: Unsigned division works as follows. Start with Q=M=T=0, use the dividend's high word (less than the divisor) as the first remainder, and feed each `rem_out` back. Before each of 32 steps, write T with the next dividend low-word bit, MSB first. The T value after step k is then bit 31-k of the 32-bit quotient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Load M and Q, clear T |
| init_m | input | 1 | Value loaded into M on init |
| init_q | input | 1 | Value loaded into Q on init |
| step | input | 1 | Perform one division step this cycle |
| t_wr | input | 1 | Write T from `t_wdata` |
| t_wdata | input | 1 | Value written to T |
| divisor | input | WIDTH | Divisor operand |
| rem_in | input | WIDTH | Incoming partial remainder |
| rem_out | output | WIDTH | Updated partial remainder (combinational) |
| q_out | output | 1 | Registered Q flag |
| m_out | output | 1 | Registered M flag |
| t_out | output | 1 | Registered T flag (quotient bit after a step) |

## Verification
Two pairs of functions can fall in the same cycle: initialise with step, and step with T-write. The bench raises `init` together with `step` on a remainder that would change Q if stepped. It then judges that only the loaded M and Q values appear and that T is zero. It also raises `step` together with `t_wr` while `t_wdata` is the opposite of the step's quotient bit. It then judges that `rem_out` used the old T and that the registered T carries the step result.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

    typedef enum logic {
        ARITH_SUB = 1'b0,
        ARITH_ADD = 1'b1
    } arith_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_INIT = 2'd1,
        ACT_STEP = 2'd2,
        ACT_TWR  = 2'd3
    } act_e;

    typedef struct packed {
        logic q;
        logic m;
        logic t;
    } status_t;

    // Matching Q and M means the remainder has the divisor's sign: subtract.
    function automatic arith_e choose_arith(input logic q, input logic m);
        return (q == m) ? ARITH_SUB : ARITH_ADD;
    endfunction

    // Initialise outranks a step, which outranks a plain T write.
    function automatic act_e choose_act(input logic init, input logic step, input logic twr);
        if (init)      return ACT_INIT;
        else if (step) return ACT_STEP;
        else if (twr)  return ACT_TWR;
        else           return ACT_HOLD;
    endfunction

endpackage

// File: rtl/divstep_addsub.sv
module divstep_addsub
    import divstep_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  arith_e           op,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    localparam int unsigned SW = WIDTH + 1;

    logic             is_sub;
    logic [WIDTH-1:0] b_eff;
    logic [SW-1:0]    sum;

    // One carry chain: subtract as a + ~b + 1.
    always_comb begin
        is_sub = (op == ARITH_SUB);
        b_eff  = is_sub ? ~opb : opb;
        sum    = {1'b0, opa} + {1'b0, b_eff} + {{(SW-1){1'b0}}, is_sub};
        res    = sum[WIDTH-1:0];
        // Carry-out for add; borrow-out is the inverted carry for subtract.
        cout   = is_sub ? ~sum[WIDTH] : sum[WIDTH];
    end

endmodule

// File: rtl/divstep_core.sv
module divstep_core
    import divstep_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] divisor,
    input  logic [WIDTH-1:0] rem_in,
    input  status_t          cur,
    output logic [WIDTH-1:0] rem_out,
    output logic             nxt_q,
    output logic             nxt_t
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] shifted;
    arith_e           op;
    logic             c_out;
    logic             top_bit;

    always_comb begin
        top_bit = rem_in[MSB];
        shifted = {rem_in[MSB-1:0], cur.t};
        op      = choose_arith(cur.q, cur.m);
    end

    divstep_addsub #(.WIDTH(WIDTH)) u_addsub (
        .opa  (shifted),
        .opb  (divisor),
        .op   (op),
        .res  (rem_out),
        .cout (c_out)
    );

    always_comb begin
        nxt_q = top_bit ^ c_out ^ cur.m;
        nxt_t = ~(nxt_q ^ cur.m);
    end

endmodule

// File: rtl/divstep_flags.sv
module divstep_flags
    import divstep_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    init,
    input  logic    init_m,
    input  logic    init_q,
    input  logic    step,
    input  logic    t_wr,
    input  logic    t_wdata,
    input  logic    nxt_q,
    input  logic    nxt_t,
    output status_t st
);
    act_e act;

    always_comb act = choose_act(init, step, t_wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            case (act)
                ACT_INIT: begin
                    st.q <= init_q;
                    st.m <= init_m;
                    st.t <= 1'b0;
                end
                ACT_STEP: begin
                    st.q <= nxt_q;
                    st.t <= nxt_t;
                end
                ACT_TWR: st.t <= t_wdata;
                default: st <= st;
            endcase
        end
    end

    AST_INIT_LOADS: assert property (@(posedge clk) disable iff (rst)
        init |=> (!st.t && st.m == $past(init_m) && st.q == $past(init_q)))
        else $error("init load mismatch"); // R2

    AST_TWR_LOADS: assert property (@(posedge clk) disable iff (rst)
        (t_wr && !init && !step) |=> (st.t == $past(t_wdata)))
        else $error("T write mismatch"); // R3

    AST_STEP_Q: assert property (@(posedge clk) disable iff (rst)
        (step && !init) |=> (st.q == $past(nxt_q)))
        else $error("step Q mismatch"); // R5

    AST_STEP_T_FOLLOWS_QM: assert property (@(posedge clk) disable iff (rst)
        (step && !init) |=> (st.t == (st.q == st.m)))
        else $error("T not equal to Q==M"); // R6

    AST_M_ONLY_BY_INIT: assert property (@(posedge clk) disable iff (rst)
        !init |=> $stable(st.m))
        else $error("M changed without init"); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!init && !step && !t_wr) |=> ($stable(st.q) && $stable(st.t)))
        else $error("flags moved while idle"); // R8

endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
    import divstep_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             init_m,
    input  logic             init_q,
    input  logic             step,
    input  logic             t_wr,
    input  logic             t_wdata,
    input  logic [WIDTH-1:0] divisor,
    input  logic [WIDTH-1:0] rem_in,
    output logic [WIDTH-1:0] rem_out,
    output logic             q_out,
    output logic             m_out,
    output logic             t_out
);
    status_t st;
    logic    nxt_q;
    logic    nxt_t;

    divstep_core #(.WIDTH(WIDTH)) u_core (
        .divisor (divisor),
        .rem_in  (rem_in),
        .cur     (st),
        .rem_out (rem_out),
        .nxt_q   (nxt_q),
        .nxt_t   (nxt_t)
    );

    divstep_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .init    (init),
        .init_m  (init_m),
        .init_q  (init_q),
        .step    (step),
        .t_wr    (t_wr),
        .t_wdata (t_wdata),
        .nxt_q   (nxt_q),
        .nxt_t   (nxt_t),
        .st      (st)
    );

    assign q_out = st.q;
    assign m_out = st.m;
    assign t_out = st.t;

    // With T-write ignored during a step, the step's quotient bit lands in T.
    AST_STEP_BEATS_TWR: assert property (@(posedge clk) disable iff (rst)
        (step && t_wr && !init) |=> (t_out == $past(nxt_t)))
        else $error("T write overrode step"); // R9

endmodule

// File: tb/divstep_unit_test.sv
module divstep_unit_test;

    localparam int W = 32;

    typedef struct packed {
        logic         q;
        logic         m;
        logic         t;
        logic [W-1:0] rem;
        logic [W-1:0] dv;
        logic [W-1:0] erem;
        logic         eq;
        logic         et;
    } vec_t;

    // Hand-derived single-step cases covering all four Q/M combinations.
    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_0003, 32'h0000_0007, 1'b0, 1'b1},
        '{1'b0, 1'b0, 1'b1, 32'h0000_0001, 32'h0000_0005, 32'hFFFF_FFFE, 1'b1, 1'b0},
        '{1'b1, 1'b0, 1'b0, 32'hFFFF_FFFE, 32'h0000_0005, 32'h0000_0001, 1'b0, 1'b1},
        '{1'b0, 1'b1, 1'b1, 32'h4000_0000, 32'h1000_0000, 32'h9000_0001, 1'b1, 1'b1},
        '{1'b1, 1'b1, 1'b0, 32'h8000_0003, 32'h0000_0010, 32'hFFFF_FFF6, 1'b1, 1'b1},
        '{1'b1, 1'b1, 1'b1, 32'h0000_0001, 32'h0000_0010, 32'hFFFF_FFF3, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 32'h8000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         init = 1'b0, init_m = 1'b0, init_q = 1'b0;
    logic         step = 1'b0, t_wr = 1'b0, t_wdata = 1'b0;
    logic [W-1:0] divisor = '0, rem_in = '0;
    logic [W-1:0] rem_out;
    logic         q_out, m_out, t_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    divstep_unit #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .init(init), .init_m(init_m), .init_q(init_q),
        .step(step), .t_wr(t_wr), .t_wdata(t_wdata), .divisor(divisor),
        .rem_in(rem_in), .rem_out(rem_out), .q_out(q_out), .m_out(m_out), .t_out(t_out)
    );

    task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_init(input logic m, input logic q);
        init = 1'b1; init_m = m; init_q = q;
        cyc();
        init = 1'b0;
    endtask

    task automatic do_twr(input logic t);
        t_wr = 1'b1; t_wdata = t;
        cyc();
        t_wr = 1'b0;
    endtask

    task automatic do_step(input logic [W-1:0] r, input logic [W-1:0] d, output logic [W-1:0] r_new);
        step = 1'b1; rem_in = r; divisor = d;
        #1 r_new = rem_out;
        @(posedge clk);
        @(negedge clk);
        step = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] r;
        logic [W-1:0] qbits;
        logic [63:0]  dvd;
        logic [W-1:0] dd;
        logic [W-1:0] tmp;

        // R1: reset state
        @(negedge clk); cyc(); cyc();
        rst = 1'b0;
        check("R1", "Q after reset", {31'b0, q_out}, 0);
        check("R1", "M after reset", {31'b0, m_out}, 0);
        check("R1", "T after reset", {31'b0, t_out}, 0);

        // Vector table: R4 remainder, R5 Q, R6 T, R7 M kept, R3 T write
        for (int i = 0; i < NV; i++) begin
            do_init(VECS[i].m, VECS[i].q);
            do_twr(VECS[i].t);
            check("R3", "T after write", {31'b0, t_out}, {31'b0, VECS[i].t});
            do_step(VECS[i].rem, VECS[i].dv, r);
            check("R4", "rem_out", r, VECS[i].erem);
            check("R5", "Q after step", {31'b0, q_out}, {31'b0, VECS[i].eq});
            check("R6", "T after step", {31'b0, t_out}, {31'b0, VECS[i].et});
            check("R7", "M after step", {31'b0, m_out}, {31'b0, VECS[i].m});
        end

        // R8: idle hold
        do_init(1'b1, 1'b1);
        do_twr(1'b1);
        cyc(); cyc(); cyc();
        check("R8", "Q held", {31'b0, q_out}, 1);
        check("R8", "M held", {31'b0, m_out}, 1);
        check("R8", "T held", {31'b0, t_out}, 1);

        // R2: init with step (and T write) in same cycle, init wins
        init = 1'b1; init_m = 1'b1; init_q = 1'b0;
        step = 1'b1; rem_in = 32'hFFFF_FFFF; divisor = 32'h0000_0001;
        t_wr = 1'b1; t_wdata = 1'b1;
        cyc();
        init = 1'b0; step = 1'b0; t_wr = 1'b0;
        check("R2", "Q after init+step", {31'b0, q_out}, 0);
        check("R2", "M after init+step", {31'b0, m_out}, 1);
        check("R2", "T after init+step", {31'b0, t_out}, 0);

        // R9: step with T write, step wins; remainder uses old T=0
        do_init(1'b0, 1'b0);
        t_wr = 1'b1; t_wdata = 1'b1;
        do_step(32'h0000_0001, 32'h0000_0005, r);
        t_wr = 1'b0;
        check("R9", "rem_out uses old T", r, 32'hFFFF_FFFD);
        check("R9", "T from step", {31'b0, t_out}, 0);
        check("R9", "Q from step", {31'b0, q_out}, 1);
        check("R7", "M after step+write", {31'b0, m_out}, 0);

        // R3: T write leaves Q and M alone
        do_init(1'b1, 1'b1);
        do_twr(1'b1);
        check("R3", "Q after T write", {31'b0, q_out}, 1);
        check("R3", "M after T write", {31'b0, m_out}, 1);

        // R1: reset after non-zero state
        rst = 1'b1; cyc(); rst = 1'b0;
        check("R1", "Q after mid reset", {31'b0, q_out}, 0);
        check("R1", "M after mid reset", {31'b0, m_out}, 0);
        check("R1", "T after mid reset", {31'b0, t_out}, 0);

        // R10: full 32-step unsigned divisions
        for (int c = 0; c < 4; c++) begin
            case (c)
                0: begin dvd = 64'd100; dd = 32'd7; end
                1: begin dvd = 64'h1234_5678_9ABC_DEF0; dd = 32'h8765_4321; end
                2: begin dvd = 64'hFFFF_FFFE_FFFF_FFFF; dd = 32'hFFFF_FFFF; end
                default: begin dvd = 64'h0000_0000_8000_0001; dd = 32'h0000_0001; end
            endcase
            do_init(1'b0, 1'b0);
            r = dvd[63:32];
            qbits = '0;
            for (int k = 31; k >= 0; k--) begin
                do_twr(dvd[k]);
                do_step(r, dd, tmp);
                r = tmp;
                qbits[k] = t_out;
            end
            check("R10", "quotient", qbits, W'(dvd / {32'b0, dd}));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule